// File: doc/BRIEF.md
# Two-Thread Alternating Slot Arbiter

This block decides, once per clock, which of two hardware threads may use a shared pipeline slot such as allocation, decoded-op cache access or retirement. Each thread presents a request (its op queue holds work), an enable (the thread is not halted) and a vector of backpressure flags from the downstream structures it fills. The number of flags per thread is a parameter. By default there are two, for the thread's share of the reorder buffer and its share of the reservation station.

A thread is eligible when it is enabled, requesting, and none of its backpressure flags is set. A one-bit turn pointer breaks ties. The thread that holds the turn wins when it is eligible. Otherwise the other thread wins if it is eligible. The turn passes to the other thread only after the holder has actually been granted. When both threads are busy they therefore alternate cycle by cycle, and a lone eligible thread takes every slot. The grant is a registered one-hot vector that is zero on idle cycles.

Top module: `pingpong_alloc_arb`

## Requirements
- R1: After reset `grant_o` is 2'b00 and the turn belongs to thread 0, so the first cycle in which both threads are eligible grants thread 0.
- R2: Thread t is eligible only when `en_i[t]` and `req_i[t]` are 1 and every bit of its backpressure slice `res_full_i[t*NUM_RES +: NUM_RES]` is 0. Any single set bit blocks the thread.
- R3: `grant_o` is registered. The inputs seen at a rising clock edge decide the value that `grant_o` holds after that edge, and the value is always 2'b00, 2'b01 (thread 0) or 2'b10 (thread 1).
- R4: When neither thread is eligible, `grant_o` is 2'b00 in the following cycle.
- R5: When the turn holder is eligible, it is granted.
- R6: When only one thread is eligible, that thread is granted regardless of the turn.
- R7: When both threads are eligible in two consecutive cycles, the second grant goes to the other thread than the first.
- R8: The turn passes to the other thread only after a cycle in which the turn holder was granted. A grant to the non-holder leaves the turn unchanged.
- R9: A thread with `en_i[t]` = 0 is never granted, whatever its request and backpressure.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 2 | Per-thread enable. 0 removes a halted thread from arbitration |
| req_i | input | 2 | Per-thread request (op queue not empty) |
| res_full_i | input | 2*NUM_RES | Backpressure flags. Bits t*NUM_RES to t*NUM_RES+NUM_RES-1 belong to thread t |
| grant_o | output | 2 | Registered one-hot grant. Bit t is thread t |

## Verification
The bench builds the arbiter with NUM_RES = 3, so each thread has one backpressure flag beyond the default two. Setting each flag alone shows that any one of them blocks its thread. The directed sequences cover these cases:
- a turn left with thread 0 while thread 1 runs alone, followed by contention that thread 0 must win;
- alternation across long runs of contention;
- halting one thread while it still requests.

A long pseudo-random phase mixes all inputs, and a behavioural model checks every cycle of it.

// File: rtl/ppa_pkg.sv
package ppa_pkg;
  localparam int unsigned NThreads = 2;
  typedef logic [NThreads-1:0] tmask_t;
endpackage

// File: rtl/ppa_elig.sv
module ppa_elig #(
  parameter int unsigned NUM_RES = 2
) (
  input  logic               en_i,
  input  logic               req_i,
  input  logic [NUM_RES-1:0] full_i,
  output logic               elig_o
);
  // any downstream share full blocks the thread
  assign elig_o = en_i & req_i & ~(|full_i);
endmodule

// File: rtl/ppa_pick.sv
module ppa_pick
  import ppa_pkg::*;
(
  input  tmask_t elig_i,
  input  logic   turn_i,
  output tmask_t pick_o,
  output logic   holder_win_o
);
  logic other;
  assign other = ~turn_i;

  always_comb begin
    pick_o = '0;
    if (elig_i[turn_i])     pick_o[turn_i] = 1'b1;
    else if (elig_i[other]) pick_o[other]  = 1'b1;
  end

  assign holder_win_o = elig_i[turn_i];
endmodule

// File: rtl/ppa_state.sv
module ppa_state
  import ppa_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  tmask_t pick_i,
  input  logic   holder_win_i,
  output tmask_t grant_o,
  output logic   turn_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_o <= '0;
      turn_o  <= 1'b0;
    end else begin
      grant_o <= pick_i;
      // turn moves only when its holder used the slot
      if (holder_win_i) turn_o <= ~turn_o;
    end
  end
endmodule

// File: rtl/pingpong_alloc_arb.sv
module pingpong_alloc_arb
  import ppa_pkg::*;
#(
  parameter int unsigned NUM_RES = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NThreads-1:0]         en_i,
  input  logic [NThreads-1:0]         req_i,
  input  logic [NThreads*NUM_RES-1:0] res_full_i,
  output logic [NThreads-1:0]         grant_o
);
  tmask_t elig;
  tmask_t pick;
  logic   holder_win;
  logic   turn_q;

  for (genvar t = 0; t < NThreads; t++) begin : g_thr
    ppa_elig #(.NUM_RES(NUM_RES)) u_elig (
      .en_i   (en_i[t]),
      .req_i  (req_i[t]),
      .full_i (res_full_i[t*NUM_RES +: NUM_RES]),
      .elig_o (elig[t])
    );
  end

  ppa_pick u_pick (
    .elig_i       (elig),
    .turn_i       (turn_q),
    .pick_o       (pick),
    .holder_win_o (holder_win)
  );

  ppa_state u_state (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pick_i       (pick),
    .holder_win_i (holder_win),
    .grant_o      (grant_o),
    .turn_o       (turn_q)
  );
endmodule

// File: rtl/ppa_arb_chk.sv
module ppa_arb_chk #(
  parameter int unsigned NUM_RES = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [1:0]           en_i,
  input logic [1:0]           req_i,
  input logic [2*NUM_RES-1:0] res_full_i,
  input logic [1:0]           grant_o,
  input logic                 turn_q
);
  logic [1:0] e;
  logic       both, both_q;

  assign e[0] = en_i[0] & req_i[0] & ~(|res_full_i[0 +: NUM_RES]);
  assign e[1] = en_i[1] & req_i[1] & ~(|res_full_i[NUM_RES +: NUM_RES]);
  assign both = &e;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) both_q <= 1'b0;
    else         both_q <= both;
  end

  a_r3_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));

  a_r4_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (e == 2'b00) |=> (grant_o == 2'b00));

  a_r9_halt0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i[0] |=> !grant_o[0]);

  a_r9_halt1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i[1] |=> !grant_o[1]);

  a_r6_lone0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (e == 2'b01) |=> (grant_o == 2'b01));

  a_r6_lone1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (e == 2'b10) |=> (grant_o == 2'b10));

  a_r5_holder: assert property (@(posedge clk_i) disable iff (!rst_ni)
    e[turn_q] |=> (grant_o == (2'b01 << $past(turn_q))));

  a_r7_alternate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (both && both_q) |=> (grant_o != $past(grant_o)));

  a_r8_turn_move: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (turn_q != $past(turn_q)) == grant_o[$past(turn_q)]);
endmodule

bind pingpong_alloc_arb ppa_arb_chk #(.NUM_RES(NUM_RES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .req_i      (req_i),
  .res_full_i (res_full_i),
  .grant_o    (grant_o),
  .turn_q     (turn_q)
);

// File: tb/tb_pingpong_alloc_arb.sv
module tb_pingpong_alloc_arb;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 3;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [1:0]    en_i = '0;
  logic [1:0]    req_i = '0;
  logic [2*NR-1:0] res_full_i = '0;
  logic [1:0]    grant_o;

  int checks = 0;
  int errors = 0;
  int m_turn = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pingpong_alloc_arb #(.NUM_RES(NR)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .req_i(req_i),
    .res_full_i(res_full_i), .grant_o(grant_o)
  );

  function automatic bit elig(int t);
    return en_i[t] && req_i[t] && (res_full_i[t*NR +: NR] == '0);
  endfunction

  task automatic check(string tag, logic [1:0] exp);
    checks++;
    if (grant_o !== exp) begin
      errors++;
      $display("FAIL %s: grant_o=%b expected=%b at %0t", tag, grant_o, exp, $time);
    end
  endtask

  // drive at negedge, model at posedge, compare at next negedge
  task automatic step(logic [1:0] en, logic [1:0] req, logic [2*NR-1:0] full, string tag);
    logic [1:0] exp;
    en_i = en; req_i = req; res_full_i = full;
    @(posedge clk);
    exp = 2'b00;
    if (elig(m_turn)) begin
      exp = 2'(1 << m_turn);
      m_turn = 1 - m_turn;
    end else if (elig(1 - m_turn)) begin
      exp = 2'(1 << (1 - m_turn));
    end
    @(negedge clk);
    check(tag, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 2'b00);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1", 2'b00);

    step(2'b11, 2'b11, '0, "R1");          // first contention -> thread 0
    for (int i = 0; i < 6; i++) step(2'b11, 2'b11, '0, "R7");
    step(2'b11, 2'b00, '0, "R4");
    step(2'b11, 2'b00, '0, "R4");
    for (int i = 0; i < 4; i++) step(2'b11, 2'b10, '0, "R6");
    step(2'b11, 2'b11, '0, "R8");          // turn unchanged by lone grants
    step(2'b11, 2'b11, '0, "R5");
    step(2'b11, 2'b01, '0, "R6");
    step(2'b11, 2'b11, '0, "R8");
    for (int b = 0; b < 2*NR; b++) begin
      step(2'b11, 2'b11, (2*NR)'(1) << b, "R2");
      step(2'b11, 2'b11, '0, "R5");
    end
    step(2'b11, 2'b11, {NR{1'b1}} | ({NR{1'b1}} << NR), "R4");
    for (int i = 0; i < 4; i++) step(2'b10, 2'b11, '0, "R9");
    for (int i = 0; i < 4; i++) step(2'b01, 2'b11, '0, "R9");
    step(2'b00, 2'b11, '0, "R9");
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] r = $urandom;
      logic [2*NR-1:0] f = (r[7:5] == 3'd0) ? r[8 +: 2*NR] : '0;
      step(r[1:0] | {r[4], r[4]}, r[3:2] | {r[4], r[4]}, f, "R3");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule